// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the pending-interrupt flags and the per-source interrupt enables for one 16-bit timer/counter with several output-compare channels (three by default), an input-capture unit and overflow detection. The counter datapath feeds it single-cycle event strobes: a compare match per channel, a capture edge, a TOP-reached pulse and an overflow pulse. It also receives a forced-compare strobe per channel, a timer-tick enable for prescaled counting, and a mode bit saying whether the capture register currently serves as TOP.

Software sees two byte-wide registers through a simple write port: a flag register, whose bits are cleared by writing ones, and an enable register. An interrupt controller sees one request line per source. It returns one acknowledge strobe per source when it takes that vector, and the acknowledge clears the flag by itself. A flag that is set in the same cycle as it is cleared stays set, so no event is lost.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset every flag, every enable bit and every interrupt request is 0.
- R2: Both registers place overflow at bit 0, compare channels A, B and C at bits 1, 2 and 3, and capture at bit 5. Bits 4, 6 and 7 of both always read 0.
- R3: A write with `reg_sel`=1 loads the enable register from the bits of `reg_wdata` at the R2 positions. The enable register keeps its value in every other cycle, including flag-register writes.
- R4: `irq_req[i]` is 1 exactly when source i's flag is set, its enable bit is 1 and `gie` is 1. The source index is 0 for overflow, 1 to 3 for compare A to C, and 4 for capture.
- R5: A compare match sampled on a cycle with `tick_en`=1 sets that channel's flag on the next cycle that has `tick_en`=1. With `tick_en` held at 1, the flag reads 1 two clock edges after the match was driven.
- R6: A forced-compare strobe never sets a compare flag. A match that comes with a forced strobe on the same channel in the same tick is dropped.
- R7: With `cap_is_top`=0 the capture flag is set by `cap_edge` and `top_hit` is ignored. With `cap_is_top`=1 it is set by `top_hit` and `cap_edge` is ignored. The flag reads 1 one edge after the strobe.
- R8: The overflow flag reads 1 one edge after an `ovf_evt` pulse.
- R9: A write with `reg_sel`=0 clears each flag whose bit in `reg_wdata` is 1. Flags written with 0 are left unchanged.
- R10: A pulse on `vec_ack[i]` clears flag i and no other flag.
- R11: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer-tick enable for prescaled counting |
| cmp_match | input | CMP_N | Per-channel compare-match strobe |
| cmp_force | input | CMP_N | Per-channel forced-compare strobe |
| cap_edge | input | 1 | Capture-input event strobe |
| top_hit | input | 1 | Counter reached TOP strobe |
| cap_is_top | input | 1 | Waveform mode uses the capture register as TOP |
| ovf_evt | input | 1 | Counter overflow strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 the enable register |
| reg_wdata | input | REG_W | Register write data |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | CMP_N+2 | Per-source vector acknowledge |
| flag_reg | output | REG_W | Flag register read value |
| mask_reg | output | REG_W | Enable register read value |
| irq_req | output | CMP_N+2 | Per-source interrupt request |

## Verification
On every cycle the assertions check the request gating by `gie`, that the reserved bits read 0, that the enable register holds between writes, and the one-edge set timing of the overflow and capture flags, including a capture driven from TOP. They also check the write-one-to-clear and acknowledge paths when no set is pending, and the two-tick delay of a compare match. Some behaviours can only be shown by the bench's scenarios. These are a compare match that a forced strobe drops, a match held back by a low tick enable, the capture source that the mode bit ignores, the full sweep of write-one-to-clear patterns, and the requests seen for every enable value.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   // Register bit positions that software decodes
   localparam int unsigned POS_OVF  = 0;
   localparam int unsigned POS_CMP0 = 1;
   localparam int unsigned POS_CAP  = 5;

   typedef enum logic {
      SEL_FLAGS   = 1'b0,
      SEL_ENABLES = 1'b1
   } reg_sel_e;

   // Source index -> register bit position
   function automatic int unsigned src_pos(input int unsigned idx, input int unsigned n_cmp);
      if (idx == 0)
         return POS_OVF;
      else if (idx <= n_cmp)
         return POS_CMP0 + idx - 1;
      else
         return POS_CAP;
   endfunction
endpackage

// File: rtl/tmr_irq_cmp_delay.sv
module tmr_irq_cmp_delay #(
   parameter int unsigned CMP_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [CMP_N-1:0] match_s,
   input  logic [CMP_N-1:0] force_s,
   output logic [CMP_N-1:0] set_o
);
   for (genvar ch = 0; ch < CMP_N; ch++) begin : g_ch
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (tick_en)
            pend_q <= match_s[ch] & ~force_s[ch];
      end
      assign set_o[ch] = pend_q & tick_en;
   end
endmodule

// File: rtl/tmr_irq_cap_sel.sv
module tmr_irq_cap_sel (
   input  logic cap_edge,
   input  logic top_hit,
   input  logic cap_is_top,
   output logic cap_set
);
   always_comb begin
      if (cap_is_top)
         cap_set = top_hit;
      else
         cap_set = cap_edge;
   end
endmodule

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set_i)
         q <= 1'b1;
      else if (clr_i)
         q <= 1'b0;
   end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
   import tmr_irq_pkg::*;
#(
   parameter int unsigned CMP_N = 3,
   parameter int unsigned REG_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic [CMP_N-1:0]   cmp_match,
   input  logic [CMP_N-1:0]   cmp_force,
   input  logic               cap_edge,
   input  logic               top_hit,
   input  logic               cap_is_top,
   input  logic               ovf_evt,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [REG_W-1:0]   reg_wdata,
   input  logic               gie,
   input  logic [CMP_N+1:0]   vec_ack,
   output logic [REG_W-1:0]   flag_reg,
   output logic [REG_W-1:0]   mask_reg,
   output logic [CMP_N+1:0]   irq_req
);
   localparam int unsigned SRC_N   = CMP_N + 2;
   localparam int unsigned CAP_IDX = SRC_N - 1;

   initial begin
      assert (CMP_N >= 1 && CMP_N <= 3)
         else $error("CMP_N must be 1 to 3");
      assert (REG_W >= POS_CAP + 1)
         else $error("REG_W too narrow for the register layout");
   end

   logic [CMP_N-1:0] cmp_set;
   logic             cap_set;
   logic [SRC_N-1:0] set_vec;
   logic [SRC_N-1:0] clr_vec;
   logic [SRC_N-1:0] flags;
   logic [SRC_N-1:0] en_q;
   logic             wr_flags;
   logic             wr_enables;
   logic             unused_wdata;

   assign wr_flags     = reg_wr && (reg_sel_e'(reg_sel) == SEL_FLAGS);
   assign wr_enables   = reg_wr && (reg_sel_e'(reg_sel) == SEL_ENABLES);
   assign unused_wdata = ^reg_wdata;

   tmr_irq_cmp_delay #(.CMP_N(CMP_N)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .match_s (cmp_match),
      .force_s (cmp_force),
      .set_o   (cmp_set)
   );

   tmr_irq_cap_sel u_cap (
      .cap_edge   (cap_edge),
      .top_hit    (top_hit),
      .cap_is_top (cap_is_top),
      .cap_set    (cap_set)
   );

   assign set_vec = {cap_set, cmp_set, ovf_evt};

   for (genvar s = 0; s < SRC_N; s++) begin : g_src
      localparam int unsigned P = src_pos(s, CMP_N);

      assign clr_vec[s] = (wr_flags & reg_wdata[P]) | vec_ack[s];

      tmr_irq_flag_cell u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[s]),
         .clr_i (clr_vec[s]),
         .q     (flags[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[s] <= 1'b0;
         else if (wr_enables)
            en_q[s] <= reg_wdata[P];
      end

      assign irq_req[s] = flags[s] & en_q[s] & gie;
   end

   always_comb begin
      flag_reg = '0;
      mask_reg = '0;
      for (int unsigned s = 0; s < SRC_N; s++) begin
         flag_reg[src_pos(s, CMP_N)] = flags[s];
         mask_reg[src_pos(s, CMP_N)] = en_q[s];
      end
   end

   // Capture sits at the top source index
   initial begin
      assert (CAP_IDX == CMP_N + 1) else $error("source index layout");
   end
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
   parameter int unsigned CMP_N = 3,
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic [CMP_N-1:0] cmp_match,
   input logic [CMP_N-1:0] cmp_force,
   input logic             cap_edge,
   input logic             top_hit,
   input logic             cap_is_top,
   input logic             ovf_evt,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [REG_W-1:0] reg_wdata,
   input logic             gie,
   input logic [CMP_N+1:0] vec_ack,
   input logic [REG_W-1:0] flag_reg,
   input logic [REG_W-1:0] mask_reg,
   input logic [CMP_N+1:0] irq_req
);
   AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> irq_req == '0); // R4

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flag_reg[4] == 1'b0 && mask_reg[4] == 1'b0 &&
      flag_reg[REG_W-1:6] == '0 && mask_reg[REG_W-1:6] == '0); // R2

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_sel) |=> $stable(mask_reg)); // R3

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag_reg[0]); // R8

   AST_CAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_is_top && top_hit |=> flag_reg[5]); // R7

   AST_CMP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cmp_match[0] && !cmp_force[0]) ##1 tick_en |=> flag_reg[1]); // R5

   AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !reg_sel && reg_wdata[0] && !ovf_evt |=> !flag_reg[0]); // R9

   AST_ACK_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ack[0] && !ovf_evt |=> !flag_reg[0]); // R10

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt && (vec_ack[0] || (reg_wr && !reg_sel && reg_wdata[0])) |=> flag_reg[0]); // R11
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.CMP_N(CMP_N), .REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .cmp_match  (cmp_match),
   .cmp_force  (cmp_force),
   .cap_edge   (cap_edge),
   .top_hit    (top_hit),
   .cap_is_top (cap_is_top),
   .ovf_evt    (ovf_evt),
   .reg_wr     (reg_wr),
   .reg_sel    (reg_sel),
   .reg_wdata  (reg_wdata),
   .gie        (gie),
   .vec_ack    (vec_ack),
   .flag_reg   (flag_reg),
   .mask_reg   (mask_reg),
   .irq_req    (irq_req)
);

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic [2:0] cmp_match = '0;
   logic [2:0] cmp_force = '0;
   logic       cap_edge = 1'b0;
   logic       top_hit = 1'b0;
   logic       cap_is_top = 1'b0;
   logic       ovf_evt = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       gie = 1'b0;
   logic [4:0] vec_ack = '0;
   logic [7:0] flag_reg;
   logic [7:0] mask_reg;
   logic [4:0] irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [7:0] ALL_FLAGS = 8'h2F;

   always #5 clk = ~clk;

   tmr_irq_flags uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmp_match(cmp_match),
      .cmp_force(cmp_force), .cap_edge(cap_edge), .top_hit(top_hit),
      .cap_is_top(cap_is_top), .ovf_evt(ovf_evt), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .gie(gie), .vec_ack(vec_ack),
      .flag_reg(flag_reg), .mask_reg(mask_reg), .irq_req(irq_req)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one clock edge, inputs changed and sampled at negedges
   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      cmp_match = '0; cmp_force = '0; cap_edge = 0; top_hit = 0;
      ovf_evt = 0; reg_wr = 0; vec_ack = '0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
      step();
      reg_wr = 0;
   endtask

   task automatic set_all();
      tick_en = 1; cap_is_top = 0;
      cmp_match = 3'b111; ovf_evt = 1; cap_edge = 1;
      step();
      idle();
      step();
   endtask

   // map 5-bit source vector to register byte
   function automatic logic [7:0] to_reg(input logic [4:0] s);
      return {2'b00, s[4], 1'b0, s[3:0]};
   endfunction

   initial begin
      step();
      chk("R1 flags", flag_reg, 8'h00);
      chk("R1 mask", mask_reg, 8'h00);
      chk("R1 irq", {3'b0, irq_req}, 8'h00);
      rst_n = 1;
      step();

      // R3 / R2: enable register write sweep
      for (int w = 0; w < 256; w++) begin
         wr(1'b1, 8'(w));
         chk("R3 R2 enable write", mask_reg, 8'(w) & ALL_FLAGS);
      end
      wr(1'b1, 8'h2F);
      wr(1'b0, 8'hFF);
      chk("R3 flag write leaves enables", mask_reg, 8'h2F);

      // R8 overflow timing
      ovf_evt = 1; step(); idle();
      chk("R8 overflow set", flag_reg, 8'h01);
      wr(1'b0, 8'h01);
      chk("R9 clear overflow", flag_reg, 8'h00);

      // R5 compare delay per channel
      for (int c = 0; c < 3; c++) begin
         cmp_match = 3'(1 << c); step(); idle();
         chk("R5 not yet", flag_reg, 8'h00);
         step();
         chk("R5 compare set", flag_reg, 8'(2 << c));
         wr(1'b0, 8'hFF);
      end
      // R5 tick gating
      tick_en = 1; cmp_match = 3'b010; step(); idle();
      tick_en = 0; step(); step();
      chk("R5 held by tick_en", flag_reg, 8'h00);
      tick_en = 1; step();
      chk("R5 set on next tick", flag_reg, 8'h04);
      wr(1'b0, 8'hFF);

      // R6 forced compare
      cmp_force = 3'b111; step(); idle(); step();
      chk("R6 force alone", flag_reg, 8'h00);
      cmp_match = 3'b101; cmp_force = 3'b101; step(); idle(); step();
      chk("R6 match with force", flag_reg, 8'h00);

      // R7 capture source selection
      cap_is_top = 0; top_hit = 1; step(); idle();
      chk("R7 top ignored", flag_reg, 8'h00);
      cap_edge = 1; step(); idle();
      chk("R7 edge sets", flag_reg, 8'h20);
      wr(1'b0, 8'h20);
      cap_is_top = 1; cap_edge = 1; step(); idle();
      chk("R7 edge ignored", flag_reg, 8'h00);
      top_hit = 1; step(); idle();
      chk("R7 top sets", flag_reg, 8'h20);
      cap_is_top = 0;
      wr(1'b0, 8'h20);

      // R9 full write-one-to-clear sweep
      for (int w = 0; w < 256; w++) begin
         set_all();
         chk("R9 all set", flag_reg, ALL_FLAGS);
         wr(1'b0, 8'(w));
         chk("R9 w1c pattern", flag_reg, ALL_FLAGS & ~8'(w));
      end
      wr(1'b0, 8'hFF);

      // R10 acknowledge per source
      for (int s = 0; s < 5; s++) begin
         set_all();
         vec_ack = 5'(1 << s); step(); idle();
         chk("R10 ack clears one", flag_reg, ALL_FLAGS & ~to_reg(5'(1 << s)));
      end
      wr(1'b0, 8'hFF);

      // R11 set wins
      set_all();
      ovf_evt = 1; vec_ack = 5'b00001; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h01;
      cap_edge = 1; step(); idle();
      chk("R11 set beats clear", flag_reg, ALL_FLAGS);
      vec_ack = 5'b10000; cap_edge = 1; step(); idle();
      chk("R11 set beats ack", flag_reg, ALL_FLAGS);

      // R4 request gating sweep: enables x gie
      for (int m = 0; m < 32; m++) begin
         wr(1'b1, to_reg(5'(m)));
         for (int g = 0; g < 2; g++) begin
            gie = g[0]; step();
            chk("R4 irq gating", {3'b0, irq_req}, g[0] ? 8'(m) : 8'h00);
         end
      end
      // R4 flags sweep with all enabled
      wr(1'b1, 8'hFF); gie = 1;
      for (int f = 0; f < 32; f++) begin
         set_all();
         wr(1'b0, ALL_FLAGS & ~to_reg(5'(f)));
         chk("R4 irq follows flags", {3'b0, irq_req}, 8'(f));
      end
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule